// File: doc/BRIEF.md
# Core Interrupt Prioritizer with Masking

This block sits between sixteen interrupt request lines and a processor core. Each line is tied to a fixed position, and a lower position means a more urgent source. A request is captured in a pending register. Software can also set or clear pending bits directly, which lets it force or withdraw an interrupt. A mask register, a global enable and a nesting control decide which pending request may be taken. When a request is taken, the block tells the core which source won and gives it the handler address. That address comes from a fixed spacing of 0x20 per position.

Three sources are special. Positions 0, 1 and 2 cannot be masked. Positions 0 and 2 are also immune to the global disable. Position 1 (the power-down source) still obeys the global disable. The block keeps an in-service register, so the core can nest handlers: with nesting on, a more urgent source interrupts a running handler. With nesting off, handlers run one after another. A return pulse from the core ends the most urgent handler that is active.

Top module: `irqp_core`

## Requirements
- R1: A high level on a request line at a rising clock edge sets that source's pending bit. The bit stays set until the source is taken or cleared by software.
- R2: A one in the software-set word sets the matching pending bits, and a one in the software-clear word clears them. When both apply to the same bit in the same cycle, or the clear meets a new line request, the clear wins.
- R3: A pending source is eligible only when its mask bit is 1 (1 = enabled). Among eligible sources, the lowest position wins.
- R4: Sources 0, 1 and 2 are eligible whatever their mask bits hold.
- R5: The global enable is off after reset. An on-pulse sets it and an off-pulse clears it, and the off-pulse wins when both arrive together. While the enable is off, only sources 0 and 2 can be taken, but every other line still latches as pending.
- R6: A grant decided in one cycle appears on the next rising edge as a one-cycle `take_o` pulse. With it come the winning position on `idx_o` and the address 0x20 × position on `vec_o`: position 13 gives 0x1A0 and position 15 gives 0x1E0. Both outputs read zero when no grant is shown. The winner's pending bit clears on that same edge, unless a new request for it arrives on that edge.
- R7: With nesting off, nothing is taken while any in-service bit is set.
- R8: With nesting on, a grant is given only when the winner's position is strictly lower than the lowest active in-service position.
- R9: A return pulse clears only the lowest set in-service bit. A lower-priority handler that is still active stays active.
- R10: After reset, pending, mask and in-service registers are zero, and `take_o`, `idx_o` and `vec_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines, position 0 most urgent |
| swset_i | input | 16 | Software set of pending bits |
| swclr_i | input | 16 | Software clear of pending bits |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 16 | New mask value, 1 enables a source |
| gie_on_i | input | 1 | Global enable set pulse |
| gie_off_i | input | 1 | Global enable clear pulse |
| nest_i | input | 1 | 1 lets urgent sources interrupt a running handler |
| rti_i | input | 1 | Return-from-handler pulse |
| take_o | output | 1 | One-cycle grant pulse |
| idx_o | output | 4 | Position of the granted source |
| vec_o | output | 16 | Handler address of the granted source |

## Verification
Several events can fall on one clock edge. A grant clears a pending bit, and on that same edge the same line can raise a new request, or software can clear or set that bit. The bench provokes the first case by holding a line high across the edge that grants it. A correct design then shows a second grant for that source once the first handler returns. The bench also drives software set and clear into the same bit, and on-pulse and off-pulse into the global enable, in one cycle. It judges the result by whether a grant appears later, compared cycle by cycle against a behavioural model.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

   localparam int unsigned DEF_NSRC   = 16;
   localparam int unsigned DEF_VEC_W  = 16;
   localparam int unsigned DEF_STRIDE = 32;

   // handler address for a source position
   function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                            input logic [31:0] stride,
                                            input logic [31:0] idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/irqp_lowest.sv
module irqp_lowest #(
   parameter int unsigned N     = 16,
   parameter bit          ARITH = 1'b1,
   localparam int unsigned IW   = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  oh_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   generate
      if (ARITH) begin : g_arith
         // isolate lowest set bit by two's complement
         assign oh_o = req_i & (~req_i + N'(1));
      end else begin : g_scan
         always_comb begin
            oh_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) oh_o = N'(1) << i;
            end
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (oh_o[i]) idx_o = idx_o | IW'(i);
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/irqp_pending.sv
module irqp_pending #(
   parameter int unsigned N = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] take_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] pend_q;

   // a grant drops the old bit; new arrivals re-latch; clear wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= ((pend_q & ~take_i) | req_i | set_i) & ~clr_i;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/irqp_inservice.sv
module irqp_inservice #(
   parameter int unsigned N     = 16,
   parameter bit          ARITH = 1'b1,
   localparam int unsigned IW   = $clog2(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          rti_i,
   input  logic [N-1:0]  take_i,
   output logic [N-1:0]  isr_o,
   output logic [IW-1:0] low_idx_o,
   output logic          busy_o
);

   logic [N-1:0] isr_q;
   logic [N-1:0] low_oh;

   irqp_lowest #(.N(N), .ARITH(ARITH)) u_low (
      .req_i (isr_q),
      .oh_o  (low_oh),
      .idx_o (low_idx_o),
      .any_o (busy_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) isr_q <= '0;
      else         isr_q <= (isr_q & ~(rti_i ? low_oh : '0)) | take_i;
   end

   assign isr_o = isr_q;

endmodule

// File: rtl/irqp_core.sv
module irqp_core #(
   parameter int unsigned       N_SRC      = irqp_pkg::DEF_NSRC,
   parameter int unsigned       VEC_W      = irqp_pkg::DEF_VEC_W,
   parameter int unsigned       VEC_BASE   = 0,
   parameter int unsigned       VEC_STRIDE = irqp_pkg::DEF_STRIDE,
   parameter logic [N_SRC-1:0]  NOMASK_SRC = N_SRC'(7),
   parameter logic [N_SRC-1:0]  NOGIE_SRC  = N_SRC'(5),
   parameter bit                ARITH      = 1'b1,
   localparam int unsigned      IW         = $clog2(N_SRC)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic [N_SRC-1:0]  swset_i,
   input  logic [N_SRC-1:0]  swclr_i,
   input  logic              mask_we_i,
   input  logic [N_SRC-1:0]  mask_wdata_i,
   input  logic              gie_on_i,
   input  logic              gie_off_i,
   input  logic              nest_i,
   input  logic              rti_i,
   output logic              take_o,
   output logic [IW-1:0]     idx_o,
   output logic [VEC_W-1:0]  vec_o
);

   generate
      if (N_SRC < 2) begin : g_bad_nsrc
         $error("irqp_core: N_SRC must be at least 2");
      end
      if (VEC_STRIDE == 0) begin : g_bad_stride
         $error("irqp_core: VEC_STRIDE must be nonzero");
      end
      if ((NOGIE_SRC & ~NOMASK_SRC) != '0) begin : g_bad_nogie
         $error("irqp_core: enable-immune sources must also be mask-immune");
      end
   endgenerate

   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] mask_q;
   logic             gie_q;
   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] cand_oh;
   logic [IW-1:0]    cand_idx;
   logic             cand_any;
   logic [N_SRC-1:0] isr_q;
   logic [IW-1:0]    isr_low_idx;
   logic             isr_busy;
   logic             grant;
   logic [N_SRC-1:0] take_oh;
   logic             take_q;
   logic [IW-1:0]    idx_q;
   logic [VEC_W-1:0] vec_q;

   irqp_pending #(.N(N_SRC)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (irq_i),
      .set_i  (swset_i),
      .clr_i  (swclr_i),
      .take_i (take_oh),
      .pend_o (pend_q)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
         gie_q  <= 1'b0;
      end else begin
         if (mask_we_i) mask_q <= mask_wdata_i;
         if (gie_off_i)     gie_q <= 1'b0;
         else if (gie_on_i) gie_q <= 1'b1;
      end
   end

   assign elig = pend_q & (mask_q | NOMASK_SRC) & (gie_q ? '1 : NOGIE_SRC);

   irqp_lowest #(.N(N_SRC), .ARITH(ARITH)) u_cand (
      .req_i (elig),
      .oh_o  (cand_oh),
      .idx_o (cand_idx),
      .any_o (cand_any)
   );

   irqp_inservice #(.N(N_SRC), .ARITH(ARITH)) u_isr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rti_i     (rti_i),
      .take_i    (take_oh),
      .isr_o     (isr_q),
      .low_idx_o (isr_low_idx),
      .busy_o    (isr_busy)
   );

   assign grant   = cand_any && (!isr_busy || (nest_i && (cand_idx < isr_low_idx)));
   assign take_oh = grant ? cand_oh : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         take_q <= 1'b0;
         idx_q  <= '0;
         vec_q  <= '0;
      end else begin
         take_q <= grant;
         idx_q  <= grant ? cand_idx : '0;
         vec_q  <= grant ? VEC_W'(irqp_pkg::vec_addr(VEC_BASE, VEC_STRIDE, 32'(cand_idx)))
                         : '0;
      end
   end

   assign take_o = take_q;
   assign idx_o  = idx_q;
   assign vec_o  = vec_q;

endmodule

// File: rtl/irqp_chk.sv
module irqp_chk #(
   parameter int unsigned      N          = 16,
   parameter logic [N-1:0]     NOMASK_SRC = N'(7),
   parameter logic [N-1:0]     NOGIE_SRC  = N'(5),
   localparam int unsigned     IW         = $clog2(N)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          take_o,
   input logic [IW-1:0] idx_o,
   input logic [N-1:0]  mask_q,
   input logic          gie_q,
   input logic          nest_i,
   input logic          isr_busy,
   input logic [IW-1:0] isr_low_idx,
   input logic [N-1:0]  isr_q,
   input logic [N-1:0]  take_oh
);

   // R3 R4: a shown grant belongs to a source that was enabled or mask-immune
   a_r3_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> |($past(mask_q | NOMASK_SRC) & (N'(1) << idx_o)));

   // R5: without the global enable only enable-immune sources are granted
   a_r5_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ($past(gie_q) || |(NOGIE_SRC & (N'(1) << idx_o))));

   // R6: at most one source is granted per cycle
   a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(take_oh));

   // R6: the granted source is marked in service when the grant shows
   a_r6_isr_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> |(isr_q & (N'(1) << idx_o)));

   // R7: no grant while a handler runs with nesting off
   a_r7_nest_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && !$past(nest_i)) |-> !$past(isr_busy));

   // R8: a pre-empting grant is strictly more urgent than the active level
   a_r8_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && $past(isr_busy)) |-> (idx_o < $past(isr_low_idx)));

endmodule

bind irqp_core irqp_chk #(
   .N          (N_SRC),
   .NOMASK_SRC (NOMASK_SRC),
   .NOGIE_SRC  (NOGIE_SRC)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .take_o      (take_o),
   .idx_o       (idx_o),
   .mask_q      (mask_q),
   .gie_q       (gie_q),
   .nest_i      (nest_i),
   .isr_busy    (isr_busy),
   .isr_low_idx (isr_low_idx),
   .isr_q       (isr_q),
   .take_oh     (take_oh)
);

// File: tb/irqp_core_tb.sv
`timescale 1ns/1ps
module irqp_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0, sset = '0, sclr = '0, mwd = '0;
   logic        mwe = 1'b0, gon = 1'b0, goff = 1'b0, nest = 1'b0, rti = 1'b0;
   logic        take;
   logic [3:0]  idx;
   logic [15:0] vec;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   int          got_idx[$];
   logic [15:0] got_vec[$];

   // behavioural reference state
   logic [15:0] m_pend = '0, m_mask = '0, m_isr = '0, m_elig, m_tb;
   logic        m_gie = 1'b0, m_take = 1'b0, m_grant;
   int          m_idx = 0, m_cand, m_low;
   logic [15:0] m_vec = '0;

   always #4 clk = ~clk;

   irqp_core u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .irq_i        (irq),
      .swset_i      (sset),
      .swclr_i      (sclr),
      .mask_we_i    (mwe),
      .mask_wdata_i (mwd),
      .gie_on_i     (gon),
      .gie_off_i    (goff),
      .nest_i       (nest),
      .rti_i        (rti),
      .take_o       (take),
      .idx_o        (idx),
      .vec_o        (vec)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_mask = '0; m_isr = '0; m_gie = 1'b0;
         m_take = 1'b0; m_idx = 0; m_vec = '0;
      end else begin
         m_elig = m_pend & (m_mask | 16'h0007) & (m_gie ? 16'hFFFF : 16'h0005);
         m_cand = -1;
         m_low  = -1;
         for (int i = 0; i < 16; i++) begin
            if (m_elig[i] && m_cand < 0) m_cand = i;
            if (m_isr[i] && m_low < 0)   m_low = i;
         end
         m_grant = (m_cand >= 0) && ((m_low < 0) || (nest && m_cand < m_low));
         m_tb = m_grant ? (16'd1 << m_cand) : 16'd0;
         if (rti && m_low >= 0) m_isr[m_low] = 1'b0;
         m_isr  = m_isr | m_tb;
         m_pend = ((m_pend & ~m_tb) | irq | sset) & ~sclr;
         if (mwe) m_mask = mwd;
         if (goff)     m_gie = 1'b0;
         else if (gon) m_gie = 1'b1;
         m_take = m_grant;
         m_idx  = m_grant ? m_cand : 0;
         m_vec  = m_grant ? 16'(m_cand * 32) : 16'd0;
      end
   end

   // per-cycle comparison and grant log (R6)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (take !== m_take || idx !== 4'(m_idx) || vec !== m_vec) begin
            failures++;
            $display("FAIL R6 model compare: act take=%0b idx=%0d vec=%h exp take=%0b idx=%0d vec=%h",
                     take, idx, vec, m_take, m_idx, m_vec);
         end
         if (take === 1'b1) begin
            got_idx.push_back(int'(idx));
            got_vec.push_back(vec);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog: act cycles=%0d exp finish", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(); @(negedge clk); endtask
   task automatic wait_cyc(input int n); repeat (n) step(); endtask

   task automatic pulse_irq(input int b);
      irq = 16'd1 << b; step(); irq = '0;
   endtask

   task automatic pulse_rti();
      rti = 1'b1; step(); rti = 1'b0;
   endtask

   task automatic set_mask(input logic [15:0] v);
      mwd = v; mwe = 1'b1; step(); mwe = 1'b0;
   endtask

   task automatic chk_seq(input string tag, input int n, input int a, input int b);
      int ea[2];
      #1;
      ea[0] = a; ea[1] = b;
      checks++;
      if (got_idx.size() != n) begin
         failures++;
         $display("FAIL %s grant count: act %0d exp %0d", tag, got_idx.size(), n);
      end else begin
         for (int i = 0; i < n; i++) begin
            if (got_idx[i] != ea[i]) begin
               failures++;
               $display("FAIL %s grant %0d: act idx=%0d exp idx=%0d", tag, i, got_idx[i], ea[i]);
            end
         end
      end
   endtask

   task automatic chk_vec(input string tag, input logic [15:0] e);
      checks++;
      if (got_vec.size() == 0 || got_vec[got_vec.size()-1] !== e) begin
         failures++;
         $display("FAIL %s vector: act %h exp %h",
                  tag, (got_vec.size() == 0) ? 16'hxxxx : got_vec[got_vec.size()-1], e);
      end
   endtask

   task automatic clear_log();
      got_idx.delete();
      got_vec.delete();
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      step();
      // R10 reset state
      checks++;
      if (take !== 1'b0 || idx !== 4'd0 || vec !== 16'd0) begin
         failures++;
         $display("FAIL R10 reset outputs: act take=%0b idx=%0d vec=%h exp 0 0 0", take, idx, vec);
      end

      // R3 R5: masked and globally disabled, then enabled step by step
      pulse_irq(5); wait_cyc(3);
      chk_seq("R3", 0, 0, 0);
      set_mask(16'h0020); wait_cyc(3);
      chk_seq("R5", 0, 0, 0);
      gon = 1'b1; step(); gon = 1'b0; wait_cyc(3);
      chk_seq("R1", 1, 5, 0);
      chk_vec("R6", 16'h00A0);
      clear_log(); pulse_rti(); wait_cyc(2);

      // R3 R7: several at once, nesting off, served in position order
      set_mask(16'hE210);
      irq = 16'h2210; step(); irq = '0; wait_cyc(6);
      chk_seq("R7", 1, 4, 0);
      clear_log(); pulse_rti(); wait_cyc(4);
      chk_seq("R3", 1, 9, 0);
      clear_log(); pulse_rti(); wait_cyc(4);
      chk_seq("R3", 1, 13, 0);
      chk_vec("R6", 16'h01A0);
      clear_log(); pulse_rti(); wait_cyc(2);
      irq = 16'hC000; step(); irq = '0; wait_cyc(4);
      chk_seq("R3", 1, 14, 0);
      chk_vec("R6", 16'h01C0);
      clear_log(); pulse_rti(); wait_cyc(4);
      chk_seq("R6", 1, 15, 0);
      chk_vec("R6", 16'h01E0);
      clear_log(); pulse_rti(); wait_cyc(2);

      // R8 R9: nesting on
      nest = 1'b1;
      set_mask(16'h0A08);
      pulse_irq(9); wait_cyc(4);
      chk_seq("R8", 1, 9, 0); clear_log();
      pulse_irq(11); wait_cyc(4);
      chk_seq("R8", 0, 0, 0);
      pulse_irq(3); wait_cyc(4);
      chk_seq("R8", 1, 3, 0); clear_log();
      pulse_rti(); wait_cyc(4);
      chk_seq("R9", 0, 0, 0);
      pulse_rti(); wait_cyc(4);
      chk_seq("R9", 1, 11, 0); clear_log();
      pulse_rti(); wait_cyc(2);
      nest = 1'b0;

      // R4 R5: immune sources while globally disabled
      goff = 1'b1; step(); goff = 1'b0;
      set_mask(16'h0040);
      pulse_irq(1); wait_cyc(4);
      chk_seq("R5", 0, 0, 0);
      pulse_irq(6); wait_cyc(4);
      chk_seq("R5", 0, 0, 0);
      pulse_irq(2); wait_cyc(4);
      chk_seq("R4", 1, 2, 0); clear_log();
      pulse_rti(); wait_cyc(4);
      chk_seq("R5", 0, 0, 0);
      gon = 1'b1; step(); gon = 1'b0; wait_cyc(4);
      chk_seq("R4", 1, 1, 0); clear_log();
      pulse_rti(); wait_cyc(4);
      chk_seq("R5", 1, 6, 0); clear_log();
      pulse_rti(); wait_cyc(2);

      // R2: software set and clear
      set_mask(16'h0180);
      sset = 16'h0080; sclr = 16'h0080; step(); sset = '0; sclr = '0; wait_cyc(4);
      chk_seq("R2", 0, 0, 0);
      sset = 16'h0100; step(); sset = '0; wait_cyc(4);
      chk_seq("R2", 1, 8, 0); clear_log();
      pulse_irq(7); wait_cyc(4);
      chk_seq("R7", 0, 0, 0);
      sclr = 16'h0080; step(); sclr = '0;
      pulse_rti(); wait_cyc(5);
      chk_seq("R2", 0, 0, 0);

      // R6 R1: request held across the granting edge re-latches
      set_mask(16'h1000);
      irq = 16'h1000; step(); step(); irq = '0; wait_cyc(4);
      chk_seq("R6", 1, 12, 0); clear_log();
      pulse_rti(); wait_cyc(4);
      chk_seq("R6", 1, 12, 0); clear_log();
      pulse_rti(); wait_cyc(4);
      chk_seq("R1", 0, 0, 0);

      // R5: on and off together, off wins
      set_mask(16'h0400);
      gon = 1'b1; goff = 1'b1; step(); gon = 1'b0; goff = 1'b0;
      pulse_irq(10); wait_cyc(4);
      chk_seq("R5", 0, 0, 0);
      gon = 1'b1; step(); gon = 1'b0; wait_cyc(4);
      chk_seq("R5", 1, 10, 0); clear_log();
      pulse_rti(); wait_cyc(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule